// File: doc/BRIEF.md
# Early Branch Resolution and Wrong-Path Squash

This block owns the fetch program counter of a five-stage in-order pipeline that always guesses "not taken" for conditional branches. Each cycle fetch steps to the next sequential word (PC + 4). When decode holds a branch-if-equal, a dedicated equality comparator checks the two register operands and a dedicated adder forms the target address. Both finish inside the decode stage.

If the branch is taken, the fetch PC is loaded with the target on the next clock edge. The one instruction that was fetched on the wrong path, which sits in the fetch stage during that cycle, is squashed. The squash works by clearing the valid bit of the fetch/decode pipeline register, so a taken branch costs one bubble. A not-taken branch costs nothing, because fetch was already on the correct path. A hold from the hazard interlock freezes fetch and decode, and while it is asserted no redirect happens. Operand forwarding into the comparator is handled elsewhere. This block sees the operand values as already resolved.

Top module: `brx_resolve`

## Requirements
- R1: While reset is asserted and right after it is released, `fetch_pc` equals the parameter RESET_PC (default 32'h0000_1000), `slot_valid` is 0 and `squash` is 0.
- R2: With `hold` low and no taken branch, `pc_next` equals `fetch_pc` + 4, and `fetch_pc` takes that value on the next rising edge.
- R3: A valid branch-if-equal whose operands differ gives `squash` = 0 and `pc_next` = `fetch_pc` + 4. There is no penalty: `slot_valid` is 1 after the edge.
- R4: A valid branch-if-equal whose operands are equal, with `hold` low, raises `squash` in the same cycle and drives `pc_next` to the branch target.
- R5: The target is `br_pc` + 4 + (sign-extended 16-bit `br_offset` × 4), taken modulo 2^32. This holds for positive, negative and extreme offsets.
- R6: After a squash edge, `fetch_pc` equals the target and `slot_valid` is 0. Exactly one slot is discarded: on the next edge with no hold and no squash, `slot_valid` returns to 1.
- R7: While `hold` is 1, `squash` is 0, `pc_next` equals `fetch_pc`, and both `fetch_pc` and `slot_valid` keep their values across the edge, even when a taken branch is present. After `hold` drops, a taken branch that is still present redirects.
- R8: Equal operands cause no squash when `br_is_beq` is 0 or when `br_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hold | input | 1 | Interlock stall: freezes fetch and decode |
| br_valid | input | 1 | Decode stage holds a live instruction |
| br_is_beq | input | 1 | Decoded instruction is a branch-if-equal |
| br_pc | input | 32 | PC of the instruction in decode |
| br_opa | input | 32 | First register operand |
| br_opb | input | 32 | Second register operand |
| br_offset | input | 16 | Signed word offset of the branch |
| fetch_pc | output | 32 | Current fetch address |
| pc_next | output | 32 | Fetch address for the next cycle |
| squash | output | 1 | Taken branch: discard the fetch-stage instruction |
| slot_valid | output | 1 | Valid bit of the fetch/decode pipeline register |

## Verification
The bench checks a taken branch against the cycle after it. A design that kept the wrong-path slot alive, or that squashed two slots, would show the wrong `slot_valid` on one of those two edges. Backward offsets and the most negative offset are used to catch a target adder that zero-extends or drops the shift. A taken branch held by the interlock has to leave the PC frozen and `squash` low, which catches a redirect that ignores the stall. Equal operands on a non-branch or an invalid decode slot would expose a comparator that is not qualified by the decode flags.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_FREEZE = 2'd1,
    SRC_TARGET = 2'd2
  } pc_src_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/brx_eq_cmp.sv
module brx_eq_cmp #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned SLICE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            equal
);
  localparam int unsigned NSLICE = XLEN / SLICE_W;

  generate
    if ((XLEN % SLICE_W) == 0 && NSLICE > 1) begin : g_sliced
      logic [NSLICE-1:0] slice_eq;
      for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        assign slice_eq[s] = (a[s*SLICE_W +: SLICE_W] == b[s*SLICE_W +: SLICE_W]);
      end
      assign equal = &slice_eq;
    end else begin : g_flat
      assign equal = (a == b);
    end
  endgenerate
endmodule

// File: rtl/brx_target_add.sv
module brx_target_add
  import brx_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  localparam int unsigned EXT_W = XLEN - OFF_W - WORD_SHIFT;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] pc_plus;

  assign disp    = {{EXT_W{offset[OFF_W-1]}}, offset, {WORD_SHIFT{1'b0}}};
  assign pc_plus = pc + XLEN'(INSN_BYTES);
  assign target  = pc_plus + disp;
endmodule

// File: rtl/brx_fetch_state.sv
module brx_fetch_state #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [XLEN-1:0] pc_d,
  input  logic            valid_d,
  output logic [XLEN-1:0] pc_q,
  output logic            valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      valid_q <= 1'b0;
    end else if (en) begin
      pc_q    <= pc_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/brx_resolve.sv
module brx_resolve
  import brx_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     OFF_W    = 16,
  parameter int unsigned     SLICE_W  = 8,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             br_valid,
  input  logic             br_is_beq,
  input  logic [XLEN-1:0]  br_pc,
  input  logic [XLEN-1:0]  br_opa,
  input  logic [XLEN-1:0]  br_opb,
  input  logic [OFF_W-1:0] br_offset,
  output logic [XLEN-1:0]  fetch_pc,
  output logic [XLEN-1:0]  pc_next,
  output logic             squash,
  output logic             slot_valid
);
  logic            ops_equal;
  logic [XLEN-1:0] target;
  logic            taken;
  logic            state_en;
  logic            valid_d;
  pc_src_e         src;

  brx_eq_cmp #(.XLEN(XLEN), .SLICE_W(SLICE_W)) u_cmp (
    .a     (br_opa),
    .b     (br_opb),
    .equal (ops_equal)
  );

  brx_target_add #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc     (br_pc),
    .offset (br_offset),
    .target (target)
  );

  // next-state selection
  always_comb begin
    taken = br_valid & br_is_beq & ops_equal;
    if (hold)       src = SRC_FREEZE;
    else if (taken) src = SRC_TARGET;
    else            src = SRC_SEQ;

    unique case (src)
      SRC_TARGET: pc_next = target;
      SRC_FREEZE: pc_next = fetch_pc;
      default:    pc_next = fetch_pc + XLEN'(INSN_BYTES);
    endcase

    squash   = (src == SRC_TARGET);
    state_en = ~hold;
    valid_d  = ~squash;
  end

  brx_fetch_state #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state_en),
    .pc_d    (pc_next),
    .valid_d (valid_d),
    .pc_q    (fetch_pc),
    .valid_q (slot_valid)
  );
endmodule

// File: rtl/brx_resolve_chk.sv
module brx_resolve_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             br_valid,
  input logic             br_is_beq,
  input logic [XLEN-1:0]  br_opa,
  input logic [XLEN-1:0]  br_opb,
  input logic [XLEN-1:0]  fetch_pc,
  input logic [XLEN-1:0]  pc_next,
  input logic             squash,
  input logic             slot_valid
);
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !squash) |=> (fetch_pc == $past(fetch_pc) + XLEN'(4)));

  assert_not_taken_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_is_beq && (br_opa != br_opb)) |-> !squash);

  assert_redirect_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (fetch_pc == $past(pc_next) && !slot_valid));

  assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !squash) |=> slot_valid);

  assert_hold_no_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !squash);

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(fetch_pc) && $stable(slot_valid)));

  assert_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_is_beq || !br_valid) |-> !squash);
endmodule

bind brx_resolve brx_resolve_chk #(.XLEN(XLEN), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold       (hold),
  .br_valid   (br_valid),
  .br_is_beq  (br_is_beq),
  .br_opa     (br_opa),
  .br_opb     (br_opb),
  .fetch_pc   (fetch_pc),
  .pc_next    (pc_next),
  .squash     (squash),
  .slot_valid (slot_valid)
);

// File: tb/brx_resolve_bench.sv
`timescale 1ns/1ps
module brx_resolve_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk;
  logic        rst_n;
  logic        hold;
  logic        br_valid;
  logic        br_is_beq;
  logic [31:0] br_pc;
  logic [31:0] br_opa;
  logic [31:0] br_opb;
  logic [15:0] br_offset;
  logic [31:0] fetch_pc;
  logic [31:0] pc_next;
  logic        squash;
  logic        slot_valid;

  int n_checks;
  int n_errors;
  bit finished;

  brx_resolve u_brx_resolve (
    .clk(clk), .rst_n(rst_n), .hold(hold), .br_valid(br_valid),
    .br_is_beq(br_is_beq), .br_pc(br_pc), .br_opa(br_opa), .br_opb(br_opb),
    .br_offset(br_offset), .fetch_pc(fetch_pc), .pc_next(pc_next),
    .squash(squash), .slot_valid(slot_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [15:0] off);
    int d;
    d = 4 * int'($signed(off));
    return pc + 32'd4 + 32'(d);
  endfunction

  // drive on falling edge, settle, then checks happen before the rising edge
  task automatic set_inputs(input logic h, input logic v, input logic beq,
                            input logic [31:0] pc, input logic [31:0] a,
                            input logic [31:0] b, input logic [15:0] off);
    @(negedge clk);
    hold = h; br_valid = v; br_is_beq = beq;
    br_pc = pc; br_opa = a; br_opb = b; br_offset = off;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    set_inputs(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 16'h0);
  endtask

  task automatic t_reset();
    hold = 0; br_valid = 0; br_is_beq = 0; br_pc = 0;
    br_opa = 0; br_opb = 0; br_offset = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "fetch_pc in reset", fetch_pc, RST_PC);
    check("R1", "slot_valid in reset", 32'(slot_valid), 32'd0);
    check("R1", "squash in reset", 32'(squash), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "fetch_pc after release", fetch_pc, RST_PC);
  endtask

  task automatic t_sequential();
    logic [31:0] pc0;
    idle();
    pc0 = fetch_pc;
    for (int i = 0; i < 3; i++) begin
      check("R2", "pc_next sequential", pc_next, pc0 + 32'(4 * i) + 32'd4);
      tick();
      check("R2", "fetch_pc advanced", fetch_pc, pc0 + 32'(4 * (i + 1)));
      check("R2", "slot_valid set", 32'(slot_valid), 32'd1);
    end
  endtask

  task automatic t_not_taken();
    logic [31:0] pc0;
    set_inputs(1'b0, 1'b1, 1'b1, 32'h0000_1008, 32'h5, 32'h6, 16'h0010);
    pc0 = fetch_pc;
    check("R3", "no squash when operands differ", 32'(squash), 32'd0);
    check("R3", "pc_next sequential", pc_next, pc0 + 32'd4);
    tick();
    check("R3", "fetch_pc", fetch_pc, pc0 + 32'd4);
    check("R3", "slot_valid kept", 32'(slot_valid), 32'd1);
  endtask

  task automatic t_taken(input logic [31:0] bpc, input logic [15:0] off);
    logic [31:0] tgt;
    tgt = exp_target(bpc, off);
    set_inputs(1'b0, 1'b1, 1'b1, bpc, 32'hABCD_1234, 32'hABCD_1234, off);
    check("R4", "squash on taken", 32'(squash), 32'd1);
    check("R5", "pc_next = target", pc_next, tgt);
    tick();
    check("R6", "fetch_pc at target", fetch_pc, tgt);
    check("R6", "slot squashed", 32'(slot_valid), 32'd0);
    idle();
    check("R6", "no second squash", 32'(squash), 32'd0);
    tick();
    check("R6", "slot refilled", 32'(slot_valid), 32'd1);
    check("R6", "fetch continues after target", fetch_pc, tgt + 32'd4);
  endtask

  task automatic t_hold();
    logic [31:0] pc0;
    logic [31:0] tgt;
    idle();
    tick();
    tgt = exp_target(32'h0000_3000, 16'h0020);
    set_inputs(1'b1, 1'b1, 1'b1, 32'h0000_3000, 32'h77, 32'h77, 16'h0020);
    pc0 = fetch_pc;
    check("R7", "no squash under hold", 32'(squash), 32'd0);
    check("R7", "pc_next frozen", pc_next, pc0);
    tick();
    tick();
    check("R7", "fetch_pc frozen", fetch_pc, pc0);
    check("R7", "slot_valid frozen", 32'(slot_valid), 32'd1);
    set_inputs(1'b0, 1'b1, 1'b1, 32'h0000_3000, 32'h77, 32'h77, 16'h0020);
    check("R7", "redirect after hold drops", 32'(squash), 32'd1);
    tick();
    check("R7", "fetch_pc at target after hold", fetch_pc, tgt);
    check("R7", "slot squashed after hold", 32'(slot_valid), 32'd0);
  endtask

  task automatic t_unqualified();
    logic [31:0] pc0;
    set_inputs(1'b0, 1'b1, 1'b0, 32'h0000_4000, 32'h9, 32'h9, 16'h0004);
    pc0 = fetch_pc;
    check("R8", "no squash for non-branch", 32'(squash), 32'd0);
    check("R8", "pc_next sequential for non-branch", pc_next, pc0 + 32'd4);
    tick();
    set_inputs(1'b0, 1'b0, 1'b1, 32'h0000_4000, 32'h9, 32'h9, 16'h0004);
    pc0 = fetch_pc;
    check("R8", "no squash for invalid slot", 32'(squash), 32'd0);
    tick();
    check("R8", "fetch_pc sequential", fetch_pc, pc0 + 32'd4);
    check("R8", "slot_valid kept", 32'(slot_valid), 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 0;
    t_reset();
    t_sequential();
    t_not_taken();
    t_taken(32'h0000_1008, 16'h0010);
    t_taken(32'h0000_2000, 16'hFFFC);
    t_taken(32'h0000_2000, 16'h8000);
    t_taken(32'h0000_0100, 16'h7FFF);
    t_hold();
    t_unqualified();
    idle();
    tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule